// File: doc/BRIEF.md
# Peripheral Slot Access Guard

This block sits between the bus masters and a row of peripheral slots. It accepts one access at a time over a valid/ready request port and registers it. In the following cycle it decides whether the access may proceed. The decision uses the target slot's protection field and the requesting master's own privilege and trust settings. An allowed access is driven to the peripheral as a one-cycle select. A refused access produces only an error response, and no select, bypass strobe or peripheral access of any kind is issued.

Software programs the protection policy through a small register window inside the block. Eight 4-bit slot fields are packed into each 32-bit control word. There is also one small register for each master. A separate address window serves modules that are not placed behind any slot. Accesses to that window skip every check and are always passed through on a bypass strobe.

Address map (request address `req_addr`, `AW` bits). The region is taken from the top two bits: 00 is the slots, 01 is the register window, 10 is the bypass window and 11 is unmapped. Within the slot region, each slot is an aligned 4 KB page, and the slot number is `req_addr[12 +: SLOT_W]`. In the register window the word index is `req_addr[7:2]`. Words 0 to NSLOT/8-1 are the control words. Word 16+m is the register for master m.

Top module: `bridge_guard`

## Requirements
- R1: After reset every control word reads 0x4444_4444, which sets supervisor protect on every slot. Every master register reads 3'b111, meaning privileged, trusted and write-enabled.
- R2: The field for slot s lives in control word s/8. Within that word, slot s%8 = 0 is at bits 31:28 and each later slot takes the next lower nibble. Field bit 2 is supervisor protect, bit 1 is write protect and bit 0 is trusted protect. Bit 3 of every nibble is reserved, always reads 0 and ignores writes.
- R3: If supervisor protect is set, the access is refused unless it carries the supervisor attribute and the master's privilege bit (bit 2 of its master register) is 1.
- R4: If write protect is set, any write to the slot is refused, whether it is a user or a supervisor write. Reads are still granted.
- R5: If trusted protect is set, any access from a master whose trusted bit (bit 1 of its master register) is 0 is refused.
- R6: A write to any slot from a master whose write-enable bit (bit 0 of its master register) is 0 is refused. Reads from that master are still granted.
- R7: A refused access returns `rsp_error`=1 with read data 0. During that response `per_sel` is all zero and `per_bypass` is 0. A granted slot access raises exactly the one-hot select bit of its slot.
- R8: Accesses to the bypass window are never refused, whatever the privilege, trust or direction. They raise `per_bypass`, leave `per_sel` at zero and return `per_rdata` on reads.
- R9: Writes to the register window take effect only when they carry the supervisor attribute and come from a trusted master. Any other write is refused and leaves every register unchanged. Reads of the window are always allowed.
- R10: `req_ready` is 1 when the block is idle. The response (`rsp_valid`=1) appears exactly one cycle after the request is accepted, and `req_ready` is 0 during that cycle. `rsp_valid` lasts one cycle.
- R11: Any access to the unmapped region (top address bits 11) is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor attribute, 0 = user |
| req_master | input | $clog2(NMST) | Requesting master number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_error | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| per_sel | output | 2**SLOT_W | One-hot slot select for granted slot accesses |
| per_bypass | output | 1 | Strobe for the bypass window |
| per_addr | output | AW | Address toward the peripherals |
| per_write | output | 1 | Direction toward the peripherals |
| per_wdata | output | 32 | Write data toward the peripherals |
| per_rdata | input | 32 | Read data from the selected peripheral |

## Verification
The bench keeps the default parameters: SLOT_W=4, NMST=4 and AW=20. This gives sixteen slots packed into two control words, so the nibble placement is checked in both the first word and the second. Four masters let one master lose privilege, another lose trust and a third lose write permission, while master 0 stays fully enabled to reprogram the policy in between scenarios. The directed scenarios cover each of the three slot checks and the write-enable bit, both alone and against a control slot. They also cover refused register writes from a user access and from an untrusted master, the bypass window used by an untrusted user master, and the unmapped region.

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int SLOT_W = 4,
  parameter int NMST   = 4,
  parameter int AW     = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_write,
  input  logic                      req_super,
  input  logic [$clog2(NMST)-1:0]   req_master,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_error,
  output logic [31:0]               rsp_rdata,
  output logic [(1<<SLOT_W)-1:0]    per_sel,
  output logic                      per_bypass,
  output logic [AW-1:0]             per_addr,
  output logic                      per_write,
  output logic [31:0]               per_wdata,
  input  logic [31:0]               per_rdata
);
  localparam int NSLOT = 1 << SLOT_W;
  localparam int NCTL  = NSLOT / 8;
  localparam int MID_W = $clog2(NMST);
  localparam int MBASE = 16;
  localparam logic [1:0] RG_SLOT = 2'b00;
  localparam logic [1:0] RG_CFG  = 2'b01;
  localparam logic [1:0] RG_BYP  = 2'b10;
  localparam logic [31:0] CTL_RST  = 32'h4444_4444;
  localparam logic [31:0] CTL_MASK = 32'h7777_7777;

  logic              busy;
  logic [AW-1:0]     q_addr;
  logic              q_write, q_super;
  logic [MID_W-1:0]  q_mid;
  logic [31:0]       q_wdata;

  logic [NCTL*32-1:0] ctl_q;
  logic [NMST*3-1:0]  mst_q;

  logic [1:0]        q_rgn;
  logic [SLOT_W-1:0] q_slot;
  logic [5:0]        q_word;
  logic [3:0]        fld;
  logic [2:0]        mreg;
  logic              m_priv, m_trust, m_wen;
  logic              cfg_ok, cfg_we, err;
  logic [31:0]       cfg_rd;

  assign q_rgn   = q_addr[AW-1:AW-2];
  assign q_slot  = q_addr[12 +: SLOT_W];
  assign q_word  = q_addr[7:2];
  assign mreg    = mst_q[int'(q_mid)*3 +: 3];
  assign m_priv  = mreg[2];
  assign m_trust = mreg[1];
  assign m_wen   = mreg[0];
  assign cfg_ok  = q_super && m_trust;
  assign cfg_we  = busy && q_rgn == RG_CFG && q_write && cfg_ok;

  always_comb begin
    int base;
    base = 32 * int'(q_slot[SLOT_W-1:3]) + 28 - 4 * int'(q_slot[2:0]);
    fld  = ctl_q[base +: 4];
  end

  always_comb begin
    cfg_rd = '0;
    for (int r = 0; r < NCTL; r++)
      if (int'(q_word) == r) cfg_rd = ctl_q[r*32 +: 32];
    for (int m = 0; m < NMST; m++)
      if (int'(q_word) == MBASE + m) cfg_rd = {29'd0, mst_q[m*3 +: 3]};
  end

  always_comb begin
    unique case (q_rgn)
      RG_SLOT: err = (fld[2] && !(q_super && m_priv))
                   || (fld[1] && q_write)
                   || (fld[0] && !m_trust)
                   || (q_write && !m_wen);
      RG_CFG:  err = q_write && !cfg_ok;
      RG_BYP:  err = 1'b0;
      default: err = 1'b1;
    endcase
  end

  assign req_ready  = !busy;
  assign rsp_valid  = busy;
  assign rsp_error  = busy && err;
  assign per_sel    = (busy && q_rgn == RG_SLOT && !err) ? NSLOT'(1) << q_slot : '0;
  assign per_bypass = busy && q_rgn == RG_BYP;
  assign per_addr   = q_addr;
  assign per_write  = q_write;
  assign per_wdata  = q_wdata;

  always_comb begin
    rsp_rdata = '0;
    if (busy && !err && !q_write) begin
      if (q_rgn == RG_CFG) rsp_rdata = cfg_rd;
      else                 rsp_rdata = per_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      q_addr  <= '0;
      q_write <= 1'b0;
      q_super <= 1'b0;
      q_mid   <= '0;
      q_wdata <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (req_valid) begin
      busy    <= 1'b1;
      q_addr  <= req_addr;
      q_write <= req_write;
      q_super <= req_super;
      q_mid   <= req_master;
      q_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= {NCTL{CTL_RST}};
      mst_q <= {NMST{3'b111}};
    end else if (cfg_we) begin
      for (int r = 0; r < NCTL; r++)
        if (int'(q_word) == r) ctl_q[r*32 +: 32] <= q_wdata & CTL_MASK;
      for (int m = 0; m < NMST; m++)
        if (int'(q_word) == MBASE + m) mst_q[m*3 +: 3] <= q_wdata[2:0];
    end
  end

  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (per_sel == '0 && !per_bypass && rsp_rdata == '0)); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_sel)); // R7
  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && !req_ready)); // R10
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_BYPASS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    per_bypass |-> (!rsp_error && per_sel == '0)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |=> ($stable(ctl_q) && $stable(mst_q))); // R9
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && per_addr[AW-1:AW-2] == 2'b11) |-> rsp_error); // R11
endmodule

// File: tb/bridge_guard_test.sv
module bridge_guard_test;
  localparam int SLOT_W = 4;
  localparam int NMST   = 4;
  localparam int AW     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_master = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_error, per_bypass, per_write;
  logic [31:0] rsp_rdata, per_wdata, per_rdata;
  logic [15:0] per_sel;
  logic [AW-1:0] per_addr;

  int checks = 0, fails = 0;
  logic [15:0] last_sel;
  logic last_byp;
  logic [31:0] rd;

  always #10 clk = ~clk;
  assign per_rdata = {12'h5A5, per_addr};

  bridge_guard #(.SLOT_W(SLOT_W), .NMST(NMST), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_super(req_super),
    .req_master(req_master), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .per_sel(per_sel),
    .per_bypass(per_bypass), .per_addr(per_addr), .per_write(per_write),
    .per_wdata(per_wdata), .per_rdata(per_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sa(input int s);
    return {2'b00, 2'b00, 4'(s), 12'h000};
  endfunction
  function automatic logic [AW-1:0] ca(input int w);
    return {2'b01, 10'd0, 6'(w), 2'b00};
  endfunction

  task automatic txn(input int m, input bit sup, input bit wr, input logic [AW-1:0] a,
                     input logic [31:0] wd, input bit exp_err, input string tag);
    req_valid = 1'b1; req_master = 2'(m); req_super = sup; req_write = wr;
    req_addr = a; req_wdata = wd;
    chk(req_ready == 1'b1, "R10 ready idle", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R10 response cycle",
        {30'd0, rsp_valid, req_ready}, 32'd2);
    chk(rsp_error == exp_err, tag, {31'd0, rsp_error}, {31'd0, exp_err});
    last_sel = per_sel; last_byp = per_bypass; rd = rsp_rdata;
    if (exp_err)
      chk(per_sel == '0 && !per_bypass && rsp_rdata == '0, "R7 refused quiet",
          {per_sel, 15'd0, per_bypass} ^ rsp_rdata, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic rd_cfg(input int w, input logic [31:0] exp, input string tag);
    txn(0, 1'b1, 1'b0, ca(w), 32'd0, 1'b0, tag);
    chk(rd == exp, tag, rd, exp);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 idle after reset",
        {30'd0, req_ready, rsp_valid}, 32'd2);
    rd_cfg(0, 32'h4444_4444, "R1 ctl word0");
    rd_cfg(1, 32'h4444_4444, "R1 ctl word1");
    for (int m = 0; m < NMST; m++) rd_cfg(16 + m, 32'd7, "R1 master reg");
  endtask

  task automatic t_default();
    txn(0, 1'b0, 1'b0, sa(3), 32'd0, 1'b1, "R3 user on default slot");
    txn(0, 1'b1, 1'b0, sa(3), 32'd0, 1'b0, "R3 supervisor on default slot");
    chk(last_sel == 16'h0008, "R7 one-hot select", {16'd0, last_sel}, 32'h8);
    chk(rd == {12'h5A5, sa(3)}, "R7 read data", rd, {12'h5A5, sa(3)});
  endtask

  task automatic t_cfg_user();
    txn(0, 1'b0, 1'b1, ca(0), 32'd0, 1'b1, "R9 user config write");
    rd_cfg(0, 32'h4444_4444, "R9 word0 unchanged");
  endtask

  task automatic t_pack();
    txn(0, 1'b1, 1'b1, ca(1), 32'hFFFF_FFFF, 1'b0, "R9 sup config write");
    rd_cfg(1, 32'h7777_7777, "R2 reserved bits zero");
    txn(0, 1'b1, 1'b1, ca(0), 32'h0200_0000, 1'b0, "R9 sup config write");
    rd_cfg(0, 32'h0200_0000, "R2 word0 readback");
    txn(1, 1'b0, 1'b1, sa(0), 32'h1, 1'b0, "R2 slot0 open");
    chk(last_sel == 16'h0001, "R7 slot0 select", {16'd0, last_sel}, 32'h1);
    txn(1, 1'b0, 1'b1, sa(1), 32'h1, 1'b1, "R4 user write protected");
    txn(0, 1'b1, 1'b1, sa(1), 32'h1, 1'b1, "R4 sup write protected");
    txn(1, 1'b0, 1'b0, sa(1), 32'h0, 1'b0, "R4 read allowed");
    txn(0, 1'b1, 1'b1, ca(1), 32'h0004_1000, 1'b0, "R9 sup config write");
    txn(0, 1'b0, 1'b0, sa(11), 32'h0, 1'b1, "R2 slot11 nibble 19:16");
    txn(0, 1'b0, 1'b0, sa(10), 32'h0, 1'b0, "R2 slot10 open");
  endtask

  task automatic t_priv();
    txn(0, 1'b1, 1'b1, ca(17), 32'h3, 1'b0, "R9 master1 write");
    rd_cfg(17, 32'd3, "R9 master1 readback");
    txn(1, 1'b1, 1'b0, sa(11), 32'h0, 1'b1, "R3 unprivileged master");
    txn(0, 1'b1, 1'b0, sa(11), 32'h0, 1'b0, "R3 privileged master");
  endtask

  task automatic t_trust();
    txn(0, 1'b1, 1'b1, ca(18), 32'h5, 1'b0, "R9 master2 write");
    txn(2, 1'b1, 1'b0, sa(12), 32'h0, 1'b1, "R5 untrusted master");
    txn(2, 1'b1, 1'b0, sa(13), 32'h0, 1'b0, "R5 untrusted on open slot");
    txn(0, 1'b0, 1'b0, sa(12), 32'h0, 1'b0, "R5 trusted master");
    txn(2, 1'b1, 1'b1, ca(0), 32'h0, 1'b1, "R9 untrusted config write");
    rd_cfg(0, 32'h0200_0000, "R9 word0 unchanged");
  endtask

  task automatic t_wen();
    txn(0, 1'b1, 1'b1, ca(19), 32'h6, 1'b0, "R9 master3 write");
    txn(3, 1'b0, 1'b1, sa(0), 32'h1, 1'b1, "R6 write disabled");
    txn(3, 1'b1, 1'b1, sa(2), 32'h1, 1'b1, "R6 sup write disabled");
    txn(3, 1'b0, 1'b0, sa(0), 32'h0, 1'b0, "R6 read allowed");
  endtask

  task automatic t_bypass();
    txn(2, 1'b0, 1'b1, 20'h8_0040, 32'h55, 1'b0, "R8 bypass write");
    chk(last_byp == 1'b1 && last_sel == '0, "R8 bypass strobe",
        {15'd0, last_byp, last_sel}, 32'h0001_0000);
    txn(2, 1'b0, 1'b0, 20'h8_0080, 32'h0, 1'b0, "R8 bypass read");
    chk(rd == {12'h5A5, 20'h8_0080}, "R8 bypass data", rd, {12'h5A5, 20'h8_0080});
  endtask

  task automatic t_unmapped();
    txn(0, 1'b1, 1'b0, 20'hC_0000, 32'h0, 1'b1, "R11 unmapped region");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_cfg_user();
    t_pack();
    t_priv();
    t_trust();
    t_wen();
    t_bypass();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule